// File: doc/BRIEF.md
# Cartridge Memory Map Decoder

This block turns a 24-bit console CPU address (an 8-bit bank and a 16-bit offset) into the select lines and addresses for the memories on a game cartridge. It uses the cartridge-select, read and write strobes and the reset line from the cartridge edge. It drives one active-low output enable per ROM chip, a linear ROM address, an active-low SRAM chip enable, an SRAM retention gate, the SRAM strobes and the SRAM address. The block is purely combinational.

A 2-bit static mode input picks the wiring the cartridge emulates:

- half-bank ROM ("low-ROM");
- full-bank ROM ("high-ROM");
- an extended full-bank layout that spreads ROM across two chips.

The decode follows the shortcuts a pair of 2-to-4 decoders would take. Because one bank bit is left out of the decode, the SRAM window is wider than the minimal one. Holding reset low puts the SRAM into its low-power retention state.

Top module: `cart_map_decoder`

## Requirements
- R1: In mode 00 (low-ROM), rom_oe_no[0] is 0 exactly when cart_ni is 0 and offset bit 15 is 1. In modes 00 and 01, rom_oe_no[1] stays 1.
- R2: In mode 00, rom_addr_o equals {bank bits 6:0, offset bits 14:0}, so bank bit 7 has no effect and banks 0x80–0xFF mirror banks 0x00–0x7F.
- R3: In mode 00 with rst_ni high, sram_ce_no is 0 exactly when cart_ni is 0, offset bit 15 is 0, and bank bits 6 and 5 are both 1 (banks 0x60–0x7F and their mirrors).
- R4: In mode 01 (high-ROM), rom_addr_o equals {bank bits 5:0, offset bits 15:0}. rom_oe_no[0] is 0 exactly when cart_ni is 0 and the SRAM window of R5 is not hit.
- R5: In mode 01 with rst_ni high, sram_ce_no is 0 exactly when offset is in 0x6000–0x7FFF, bank bit 5 is 1 and bank bit 6 is 0. cart_ni, bank bit 4 and bank bit 7 play no part.
- R6: In mode 10 (extended high-ROM), the SRAM window is that of R5 with bank bit 6 also ignored. The ROM address is that of R4. A ROM access with bank bit 7 = 1 enables rom_oe_no[0], and one with bank bit 7 = 0 enables rom_oe_no[1].
- R7: sram_addr_o bits 12:0 equal offset bits 12:0. Bits 14:13 equal offset bits 14:13 in modes 00 and 11, and bank bits 1:0 in modes 01 and 10.
- R8: While rst_ni is 0, sram_ce_no is 1 and sram_ce2_o is 0 whatever the address. While rst_ni is 1, sram_ce2_o is 1.
- R9: sram_we_no equals wr_ni and sram_oe_no equals rd_ni in every mode.
- R10: Mode 11 is a safe setting: both ROM enables and sram_ce_no stay 1 and bus_drive_o stays 0.
- R11: At most one ROM enable is active, and no ROM enable is active together with sram_ce_no.
- R12: bus_drive_o is 1 exactly when rd_ni is 0 and exactly one of the ROM enables and sram_ce_no is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 2 | Map mode: 00 low-ROM, 01 high-ROM, 10 extended high-ROM, 11 off |
| bank_i | input | 8 | CPU address bank byte |
| ofs_i | input | 16 | CPU address offset within the bank |
| cart_ni | input | 1 | Active-low cartridge-select from the console |
| rd_ni | input | 1 | Active-low read strobe |
| wr_ni | input | 1 | Active-low write strobe |
| rst_ni | input | 1 | Active-low console reset; low also while powered down |
| rom_oe_no | output | 2 | Active-low output enable, one per ROM chip |
| rom_addr_o | output | 22 | Linear ROM address |
| sram_ce_no | output | 1 | Active-low SRAM chip enable |
| sram_ce2_o | output | 1 | Active-high SRAM retention gate |
| sram_we_no | output | 1 | Active-low SRAM write strobe |
| sram_oe_no | output | 1 | Active-low SRAM output enable |
| sram_addr_o | output | 15 | SRAM address |
| bus_drive_o | output | 1 | High when exactly one device drives the data bus on a read |

## Verification
The hardest case to reach is a high-ROM access that asserts cartridge-select while also landing in the SRAM window. On a real console the two never coincide, so only the block's priority rule keeps the data bus free of contention. Directed vectors drive cart_ni low at window edges such as 0x3F:6000, 0x1F:6000 and 0x20:5FFF. A long run of random vectors then biases the offset toward the 0x6000–0x7FFF band and the bank toward 0x20–0x7F, in every mode, with reset both high and low. Each vector is compared against an address-range model.

// File: rtl/cart_map_pkg.sv
`timescale 1ns/1ps
package cart_map_pkg;
  localparam int BANK_W    = 8;
  localparam int OFS_W     = 16;
  localparam int ROM_AW    = 22;
  localparam int SRAM_AW   = 15;
  localparam int ROM_CHIPS = 2;
  localparam int CHIP_W    = (ROM_CHIPS > 1) ? $clog2(ROM_CHIPS) : 1;

  typedef enum logic [1:0] {
    MAP_LO   = 2'b00,
    MAP_HI   = 2'b01,
    MAP_EXHI = 2'b10,
    MAP_OFF  = 2'b11
  } map_mode_e;

  typedef struct packed {
    logic              rom_sel;
    logic [CHIP_W-1:0] chip;
    logic              sram_sel;
    logic [ROM_AW-1:0] rom_addr;
    logic [1:0]        sram_hi;
  } map_dec_t;
endpackage

// File: rtl/cart_lo_map.sv
`timescale 1ns/1ps
module cart_lo_map
  import cart_map_pkg::*;
(
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              cart_ni,
  output map_dec_t          dec_o
);
  logic unused_mirror;
  assign unused_mirror = bank_i[7];

  always_comb begin
    dec_o          = '0;
    // offset bit 15 splits ROM half from SRAM half
    dec_o.rom_sel  = !cart_ni && ofs_i[15];
    dec_o.sram_sel = !cart_ni && !ofs_i[15] && bank_i[6] && bank_i[5];
    dec_o.rom_addr = {bank_i[6:0], ofs_i[14:0]};
    dec_o.sram_hi  = ofs_i[14:13];
  end
endmodule

// File: rtl/cart_hi_map.sv
`timescale 1ns/1ps
module cart_hi_map
  import cart_map_pkg::*;
#(
  parameter bit EXTENDED = 1'b0
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              cart_ni,
  output map_dec_t          dec_o
);
  logic win_ofs, win_bank, sram_hit;
  logic unused_b7;
  assign unused_b7 = bank_i[7];

  assign win_ofs = !ofs_i[15] && ofs_i[14] && ofs_i[13];

  generate
    if (EXTENDED) begin : g_ext
      assign win_bank = bank_i[5];
    end else begin : g_std
      assign win_bank = bank_i[5] && !bank_i[6];
    end
  endgenerate

  assign sram_hit = win_ofs && win_bank;

  always_comb begin
    dec_o          = '0;
    dec_o.sram_sel = sram_hit;
    // SRAM window wins so ROM never drives during an SRAM hit
    dec_o.rom_sel  = !cart_ni && !sram_hit;
    dec_o.chip     = (EXTENDED && !bank_i[7]) ? CHIP_W'(1) : CHIP_W'(0);
    dec_o.rom_addr = {bank_i[5:0], ofs_i};
    dec_o.sram_hi  = bank_i[1:0];
  end
endmodule

// File: rtl/cart_sram_gate.sv
`timescale 1ns/1ps
module cart_sram_gate (
  input  logic sel_i,
  input  logic rst_ni,
  output logic ce_no,
  output logic ce2_o
);
  // reset low parks the SRAM in retention regardless of decode
  assign ce_no = !(sel_i && rst_ni);
  assign ce2_o = rst_ni;
endmodule

// File: rtl/cart_map_decoder.sv
`timescale 1ns/1ps
module cart_map_decoder
  import cart_map_pkg::*;
(
  input  logic [1:0]           mode_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic [OFS_W-1:0]     ofs_i,
  input  logic                 cart_ni,
  input  logic                 rd_ni,
  input  logic                 wr_ni,
  input  logic                 rst_ni,
  output logic [ROM_CHIPS-1:0] rom_oe_no,
  output logic [ROM_AW-1:0]    rom_addr_o,
  output logic                 sram_ce_no,
  output logic                 sram_ce2_o,
  output logic                 sram_we_no,
  output logic                 sram_oe_no,
  output logic [SRAM_AW-1:0]   sram_addr_o,
  output logic                 bus_drive_o
);
  localparam int CNT_W = $clog2(ROM_CHIPS + 2);

  map_dec_t lo_dec, sel;
  map_dec_t hi_dec [2];
  logic [CNT_W-1:0] act_cnt;

  cart_lo_map i_lo (.bank_i(bank_i), .ofs_i(ofs_i), .cart_ni(cart_ni), .dec_o(lo_dec));

  for (genvar v = 0; v < 2; v++) begin : g_hi
    cart_hi_map #(.EXTENDED(v == 1)) i_hi (
      .bank_i(bank_i), .ofs_i(ofs_i), .cart_ni(cart_ni), .dec_o(hi_dec[v])
    );
  end

  always_comb begin
    unique case (map_mode_e'(mode_i))
      MAP_LO:   sel = lo_dec;
      MAP_HI:   sel = hi_dec[0];
      MAP_EXHI: sel = hi_dec[1];
      default: begin
        sel          = lo_dec;
        sel.rom_sel  = 1'b0;
        sel.sram_sel = 1'b0;
      end
    endcase
  end

  for (genvar c = 0; c < ROM_CHIPS; c++) begin : g_rom_oe
    assign rom_oe_no[c] = !(sel.rom_sel && (sel.chip == CHIP_W'(c)));
  end

  cart_sram_gate i_gate (
    .sel_i(sel.sram_sel), .rst_ni(rst_ni), .ce_no(sram_ce_no), .ce2_o(sram_ce2_o)
  );

  assign rom_addr_o  = sel.rom_addr;
  assign sram_addr_o = {sel.sram_hi, ofs_i[12:0]};
  assign sram_we_no  = wr_ni;
  assign sram_oe_no  = rd_ni;

  always_comb begin
    act_cnt = CNT_W'(!sram_ce_no);
    for (int c = 0; c < ROM_CHIPS; c++) act_cnt = act_cnt + CNT_W'(!rom_oe_no[c]);
  end

  assign bus_drive_o = !rd_ni && (act_cnt == CNT_W'(1));
endmodule

// File: rtl/cart_map_checker.sv
`timescale 1ns/1ps
module cart_map_checker
  import cart_map_pkg::*;
(
  input logic [1:0]           mode_i,
  input logic [BANK_W-1:0]    bank_i,
  input logic [OFS_W-1:0]     ofs_i,
  input logic                 cart_ni,
  input logic                 rd_ni,
  input logic                 rst_ni,
  input logic [ROM_CHIPS-1:0] rom_oe_no,
  input logic                 sram_ce_no,
  input logic                 sram_ce2_o,
  input logic                 bus_drive_o
);
  logic known;
  assign known = !$isunknown({mode_i, bank_i, ofs_i, cart_ni, rd_ni, rst_ni,
                              rom_oe_no, sram_ce_no, sram_ce2_o, bus_drive_o});

  always_comb begin
    if (known) begin
      AST_ROM_ONE_CHIP: assert ($onehot0(~rom_oe_no)); // R11
      AST_ROM_SRAM_EXCL: assert (sram_ce_no || (&rom_oe_no)); // R11
      AST_RST_RETAIN: assert (rst_ni || (sram_ce_no && !sram_ce2_o)); // R8
      AST_OFF_QUIET: assert (mode_i != 2'b11 || ((&rom_oe_no) && sram_ce_no && !bus_drive_o)); // R10
      AST_LO_ROM_HALF: assert (mode_i != 2'b00 || rom_oe_no[0] || (ofs_i[15] && !cart_ni)); // R1
      AST_HI_SRAM_BANK: assert (mode_i != 2'b01 || sram_ce_no || (bank_i[5] && !bank_i[6])); // R5
      AST_DRIVE_ON_READ: assert (!bus_drive_o || !rd_ni); // R12
    end
  end
endmodule

bind cart_map_decoder cart_map_checker i_cart_map_checker (
  .mode_i(mode_i), .bank_i(bank_i), .ofs_i(ofs_i), .cart_ni(cart_ni),
  .rd_ni(rd_ni), .rst_ni(rst_ni), .rom_oe_no(rom_oe_no),
  .sram_ce_no(sram_ce_no), .sram_ce2_o(sram_ce2_o), .bus_drive_o(bus_drive_o)
);

// File: tb/test_cart_map_decoder.sv
`timescale 1ns/1ps
module test_cart_map_decoder;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0]  mode_i = 2'b00;
  logic [7:0]  bank_i = '0;
  logic [15:0] ofs_i = '0;
  logic        cart_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1, rst_ni = 1'b0;
  logic [1:0]  rom_oe_no;
  logic [21:0] rom_addr_o;
  logic        sram_ce_no, sram_ce2_o, sram_we_no, sram_oe_no, bus_drive_o;
  logic [14:0] sram_addr_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  cart_map_decoder i_cart_map_decoder (
    .mode_i(mode_i), .bank_i(bank_i), .ofs_i(ofs_i), .cart_ni(cart_ni),
    .rd_ni(rd_ni), .wr_ni(wr_ni), .rst_ni(rst_ni), .rom_oe_no(rom_oe_no),
    .rom_addr_o(rom_addr_o), .sram_ce_no(sram_ce_no), .sram_ce2_o(sram_ce2_o),
    .sram_we_no(sram_we_no), .sram_oe_no(sram_oe_no), .sram_addr_o(sram_addr_o),
    .bus_drive_o(bus_drive_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h (mode %0d addr %02h:%04h cart %0b rst %0b)",
               tag, act, exp, mode_i, bank_i, ofs_i, cart_ni, rst_ni);
    end
  endtask

  // reference model: address ranges in plain integers
  task automatic compare();
    int bk, of, md, n_act, exp_rom, exp_sa;
    bit rom0, rom1, win, sram_on, lo_like;
    string tag;
    bk = int'(bank_i); of = int'(ofs_i); md = int'(mode_i);
    rom0 = 0; rom1 = 0; win = 0; exp_rom = 0;
    lo_like = (md == 0) || (md == 3);
    case (md)
      0: begin
        rom0 = !cart_ni && of >= 32768;                             // R1
        win  = !cart_ni && of < 32768 && (bk % 128) >= 96;          // R3
        exp_rom = (bk % 128) * 32768 + (of % 32768);                // R2
      end
      1, 2: begin
        win = of >= 24576 && of < 32768 && (bk % 64) >= 32 &&
              (md == 2 || (bk % 128) < 64);                         // R5 R6
        rom0 = !cart_ni && !win && (md == 1 || bk >= 128);          // R4
        rom1 = !cart_ni && !win && md == 2 && bk < 128;             // R6
        exp_rom = (bk % 64) * 65536 + of;
      end
      default: ;                                                    // R10
    endcase
    sram_on = win && rst_ni;                                        // R8
    exp_sa = (of % 8192) + 8192 * (lo_like ? ((of / 8192) % 4) : (bk % 4)); // R7
    n_act = int'(rom0) + int'(rom1) + int'(sram_on);
    tag = (md == 0) ? "R1" : (md == 1) ? "R4" : (md == 2) ? "R6" : "R10";
    chk(rom_oe_no == {!rom1, !rom0}, tag, rom_oe_no, {!rom1, !rom0});
    if (md != 3) chk(rom_addr_o == 22'(exp_rom), (md == 0) ? "R2" : "R4", rom_addr_o, exp_rom);
    tag = !rst_ni ? "R8" : (md == 0) ? "R3" : (md == 1) ? "R5" : (md == 2) ? "R6" : "R10";
    chk(sram_ce_no == !sram_on, tag, sram_ce_no, !sram_on);
    chk(sram_ce2_o == rst_ni, "R8", sram_ce2_o, rst_ni);
    chk(sram_we_no == wr_ni && sram_oe_no == rd_ni, "R9", {sram_we_no, sram_oe_no}, {wr_ni, rd_ni});
    chk(sram_addr_o == 15'(exp_sa), "R7", sram_addr_o, exp_sa);
    chk(bus_drive_o == (!rd_ni && n_act == 1), "R12", bus_drive_o, (!rd_ni && n_act == 1));
    chk(n_act <= 1, "R11", n_act, 1);
  endtask

  task automatic apply(input logic [1:0] m, input logic [7:0] b, input logic [15:0] o,
                       input logic c, input logic r, input logic w, input logic rs);
    @(negedge clk);
    mode_i = m; bank_i = b; ofs_i = o; cart_ni = c; rd_ni = r; wr_ni = w; rst_ni = rs;
    @(posedge clk);
    #1;
    compare();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // reset state: SRAM parked (R8)
    apply(2'b00, 8'h70, 16'h6000, 1'b0, 1'b0, 1'b1, 1'b0);
    apply(2'b01, 8'h30, 16'h6000, 1'b1, 1'b0, 1'b0, 1'b0);
    // low-ROM edges (R1 R2 R3)
    apply(2'b00, 8'h7D, 16'h7FFF, 1'b0, 1'b0, 1'b1, 1'b1);
    apply(2'b00, 8'h7E, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1);
    apply(2'b00, 8'h5F, 16'h7FFF, 1'b0, 1'b0, 1'b1, 1'b1);
    apply(2'b00, 8'h60, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1);
    apply(2'b00, 8'h00, 16'h8000, 1'b0, 1'b0, 1'b1, 1'b1);
    apply(2'b00, 8'h80, 16'h8000, 1'b0, 1'b0, 1'b1, 1'b1);
    apply(2'b00, 8'hFF, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b1);
    // high-ROM window edges and contention priority (R4 R5)
    apply(2'b01, 8'h3F, 16'h6000, 1'b0, 1'b0, 1'b1, 1'b1);
    apply(2'b01, 8'h1F, 16'h6000, 1'b0, 1'b0, 1'b1, 1'b1);
    apply(2'b01, 8'h20, 16'h5FFF, 1'b0, 1'b0, 1'b1, 1'b1);
    apply(2'b01, 8'h30, 16'h7FFF, 1'b1, 1'b0, 1'b1, 1'b1);
    apply(2'b01, 8'h70, 16'h6000, 1'b0, 1'b0, 1'b1, 1'b1);
    apply(2'b01, 8'hC0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1);
    // extended: chip split by bank bit 7, window ignores bit 6 (R6)
    apply(2'b10, 8'hC0, 16'h1234, 1'b0, 1'b0, 1'b1, 1'b1);
    apply(2'b10, 8'h40, 16'h1234, 1'b0, 1'b0, 1'b1, 1'b1);
    apply(2'b10, 8'h70, 16'h6000, 1'b0, 1'b0, 1'b1, 1'b1);
    apply(2'b10, 8'hF3, 16'h7ABC, 1'b1, 1'b1, 1'b0, 1'b1);
    // safe mode (R10)
    apply(2'b11, 8'hC0, 16'h8000, 1'b0, 1'b0, 1'b1, 1'b1);
    apply(2'b11, 8'h70, 16'h6000, 1'b0, 1'b0, 1'b0, 1'b1);
    // random sweep, biased toward the SRAM bands
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] rv;
      logic [7:0]  b;
      logic [15:0] o;
      rv = $urandom;
      b = rv[7:0];
      o = rv[23:8];
      if (rv[24]) o[15:13] = 3'b011;
      if (rv[25]) b[5] = 1'b1;
      apply(rv[27:26], b, o, rv[28], rv[29], rv[30], (rv[31] | rv[24]));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule